// File: doc/BRIEF.md
# Labeled Memory Ordering Issue Controller

This block sits between a processor's in-order queue of memory operations and a memory port that accepts several requests at once. Every operation carries a two-bit synchronization label. A mode input chooses between two relaxed orderings: weak ordering, where every labeled operation acts as a full fence, and release consistency, where acquires and releases each fence in one direction only. The controller accepts an operation from the queue only when the selected ordering rules allow it. It gives each accepted operation a tag and keeps that tag busy until memory returns an acknowledgement carrying it. Acknowledgements may come back in any order.

Operations that pass the gate are placed in a registered request stage and held there until memory takes them. The controller also refuses any access whose address matches an outstanding write. This keeps the thread's own data dependences intact. A stall output shows when the head of the queue is held back for ordering or for a same-address hazard, as opposed to a lack of free tags or memory backpressure.

Top module: `ord_issue_ctrl`

## Requirements
- R1: Label codes are 00 data, 01 acquire, 10 release and 11 full synchronization. Mode 0 selects weak ordering and mode 1 selects release consistency. After reset nothing is outstanding, mem_req_valid is 0, and a data operation is ready to be accepted with stall low.
- R2: In weak ordering, an operation with a nonzero label is not accepted while any earlier operation is outstanding.
- R3: In weak ordering, no operation is accepted while an operation with a nonzero label is outstanding.
- R4: In release consistency, no operation is accepted while an acquire or full-synchronization operation is outstanding.
- R5: In release consistency, a release or full-synchronization operation is not accepted while any earlier operation is outstanding.
- R6: In release consistency, an operation is accepted while a release is outstanding, and an acquire is accepted while data operations are outstanding, provided no other rule blocks it.
- R7: Data operations are accepted back to back with no ordering wait. Their acknowledgements may arrive in any order, and each one frees the tag it carries.
- R8: An operation whose address equals that of an outstanding write is not accepted. Reads to an address with only reads outstanding are not held back by this rule.
- R9: With DEPTH operations outstanding, nothing is accepted. This condition alone does not raise stall.
- R10: The cycle after an acceptance, mem_req_valid is 1 and the request carries that operation's address, its write flag and the lowest tag that was free. The request is held unchanged while mem_req_ready is 0, and no operation is accepted while a held request is not being taken. An acknowledgement carrying a tag that is not outstanding has no effect.
- R11: stall is 1 exactly when op_valid is 1 and the operation is held back by an ordering rule (R2 to R5) or by the address hazard (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 weak ordering, 1 release consistency; changed only when idle |
| op_valid | input | 1 | Queue head holds an operation |
| op_ready | output | 1 | Controller accepts the head this cycle |
| op_label | input | 2 | Synchronization label of the head |
| op_write | input | 1 | Head is a write |
| op_addr | input | AW | Address of the head |
| stall | output | 1 | Head held back for ordering or address hazard |
| mem_req_valid | output | 1 | Registered request to memory is pending |
| mem_req_ready | input | 1 | Memory takes the pending request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request address |
| mem_req_tag | output | TW | Tag assigned to the request |
| mem_ack_valid | input | 1 | Memory reports a completion |
| mem_ack_tag | input | TW | Tag of the completed request |

## Verification
A tag left busy by mistake shows up as a fence that never opens. A later labeled operation, or any operation that follows an acquire, then keeps op_ready low with stall high in the very next offered cycle. A tag freed too early, or an acknowledgement of an idle tag that is wrongly counted, lets a release or synchronization through while work is still in flight. A wrong choice of free tag is visible on mem_req_tag one cycle after acceptance. The bench keeps its own table of outstanding tags and compares op_ready, stall and the request fields in every cycle, so a wrong internal state is reported at the first operation it affects.

// File: rtl/ord_pkg.sv
package ord_pkg;
  typedef enum logic [1:0] {
    LBL_DATA = 2'b00,
    LBL_ACQ  = 2'b01,
    LBL_REL  = 2'b10,
    LBL_FULL = 2'b11
  } lbl_e;

  localparam logic MODE_WO = 1'b0;
  localparam logic MODE_RC = 1'b1;
endpackage

// File: rtl/ord_free_pick.sv
module ord_free_pick #(
  parameter int DEPTH = 8,
  parameter int TW    = 3
) (
  input  logic [DEPTH-1:0] busy,
  output logic             found,
  output logic [TW-1:0]    idx
);
  // lowest free index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = TW'(i);
      end
    end
  end
endmodule

// File: rtl/ord_tag_table.sv
module ord_tag_table #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 3,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [TW-1:0]    alloc_tag,
  input  logic [AW-1:0]    alloc_addr,
  input  logic             alloc_write,
  input  logic [1:0]       alloc_label,
  input  logic             ack_valid,
  input  logic [TW-1:0]    ack_tag,
  input  logic [AW-1:0]    chk_addr,
  output logic [DEPTH-1:0] busy,
  output logic [CW-1:0]    cnt,
  output logic             hazard,
  output logic             any_sync,
  output logic             any_acq
);
  logic [AW-1:0] ent_addr  [DEPTH];
  logic          ent_write [DEPTH];
  logic [1:0]    ent_label [DEPTH];

  // status bits: reset, set on allocation, cleared by a matching ack
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_en && alloc_tag == TW'(i))
          busy[i] <= 1'b1;
        else if (ack_valid && ack_tag == TW'(i))
          busy[i] <= 1'b0;
      end
    end
  end

  // payload: loaded on allocation only, qualified by busy
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_en && alloc_tag == TW'(i)) begin
        ent_addr[i]  <= alloc_addr;
        ent_write[i] <= alloc_write;
        ent_label[i] <= alloc_label;
      end
    end
  end

  always_comb begin
    cnt      = '0;
    hazard   = 1'b0;
    any_sync = 1'b0;
    any_acq  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      cnt = cnt + CW'(busy[i]);
      if (busy[i] && ent_write[i] && ent_addr[i] == chk_addr) hazard = 1'b1;
      if (busy[i] && ent_label[i] != 2'b00) any_sync = 1'b1;
      if (busy[i] && ent_label[i][0]) any_acq = 1'b1;
    end
  end
endmodule

// File: rtl/ord_gate.sv
module ord_gate
  import ord_pkg::*;
(
  input  logic       mode,
  input  logic [1:0] label,
  input  logic       cnt_zero,
  input  logic       any_sync,
  input  logic       any_acq,
  output logic       order_ok
);
  always_comb begin
    if (mode == MODE_WO) begin
      // every labeled op is a two-sided fence
      order_ok = !any_sync && (label == LBL_DATA || cnt_zero);
    end else begin
      // acquire side blocks later ops, release side waits for earlier ops
      order_ok = !any_acq && (!label[1] || cnt_zero);
    end
  end
endmodule

// File: rtl/ord_issue_ctrl.sv
module ord_issue_ctrl #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [1:0]    op_label,
  input  logic          op_write,
  input  logic [AW-1:0] op_addr,
  output logic          stall,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [TW-1:0] mem_req_tag,
  input  logic          mem_ack_valid,
  input  logic [TW-1:0] mem_ack_tag
);
  localparam int CW = TW + 1;

  logic [DEPTH-1:0] busy;
  logic [CW-1:0]    cnt;
  logic             hazard;
  logic             any_sync;
  logic             any_acq;
  logic             free_found;
  logic [TW-1:0]    free_tag;
  logic             order_ok;
  logic             slot_free;
  logic             accept;

  ord_tag_table #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .CW(CW)) u_table (
    .clk         (clk),
    .rst         (rst),
    .alloc_en    (accept),
    .alloc_tag   (free_tag),
    .alloc_addr  (op_addr),
    .alloc_write (op_write),
    .alloc_label (op_label),
    .ack_valid   (mem_ack_valid),
    .ack_tag     (mem_ack_tag),
    .chk_addr    (op_addr),
    .busy        (busy),
    .cnt         (cnt),
    .hazard      (hazard),
    .any_sync    (any_sync),
    .any_acq     (any_acq)
  );

  ord_free_pick #(.DEPTH(DEPTH), .TW(TW)) u_pick (
    .busy  (busy),
    .found (free_found),
    .idx   (free_tag)
  );

  ord_gate u_gate (
    .mode     (mode),
    .label    (op_label),
    .cnt_zero (cnt == '0),
    .any_sync (any_sync),
    .any_acq  (any_acq),
    .order_ok (order_ok)
  );

  assign slot_free = !mem_req_valid || mem_req_ready;
  assign op_ready  = slot_free && free_found && order_ok && !hazard;
  assign accept    = op_valid && op_ready;
  assign stall     = op_valid && !(order_ok && !hazard);

  // registered request stage toward memory
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
    end else if (accept) begin
      mem_req_valid <= 1'b1;
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mem_req_write <= op_write;
      mem_req_addr  <= op_addr;
      mem_req_tag   <= free_tag;
    end
  end
endmodule

// File: rtl/ord_issue_ctrl_chk.sv
module ord_issue_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = TW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          mode,
  input logic          op_valid,
  input logic          op_ready,
  input logic [1:0]    op_label,
  input logic          stall,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [TW-1:0] mem_req_tag,
  input logic [AW-1:0] mem_req_addr,
  input logic          accept,
  input logic [CW-1:0] cnt,
  input logic          any_sync,
  input logic          any_acq,
  input logic          hazard
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  assert_wo_sync_drained_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == 1'b0 && op_label != 2'b00) |-> (cnt == '0));

  assert_wo_sync_fence_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == 1'b0) |-> !any_sync);

  assert_rc_acq_fence_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == 1'b1) |-> !any_acq);

  assert_rc_rel_drained_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == 1'b1 && op_label[1]) |-> (cnt == '0));

  assert_no_raw_hazard_R8: assert property (@(posedge clk) disable iff (rst)
    accept |-> !hazard);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    accept |-> (cnt < FULL_CNT));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);

  assert_req_follows_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_req_valid);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_tag) && $stable(mem_req_addr)));

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (stall && op_valid) |-> !op_ready);
endmodule

bind ord_issue_ctrl ord_issue_ctrl_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode          (mode),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .op_label      (op_label),
  .stall         (stall),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_tag   (mem_req_tag),
  .mem_req_addr  (mem_req_addr),
  .accept        (accept),
  .cnt           (cnt),
  .any_sync      (any_sync),
  .any_acq       (any_acq),
  .hazard        (hazard)
);

// File: tb/ord_issue_ctrl_bench.sv
`timescale 1ns/1ps
module ord_issue_ctrl_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int TW    = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          mode;
  logic          op_valid;
  logic          op_ready;
  logic [1:0]    op_label;
  logic          op_write;
  logic [AW-1:0] op_addr;
  logic          stall;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic          mem_ack_valid;
  logic [TW-1:0] mem_ack_tag;

  always #2 clk = ~clk;

  ord_issue_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ord_issue_ctrl (.*);

  int n_chk  = 0;
  int n_fail = 0;

  // bench model of outstanding tags
  bit            m_busy [DEPTH];
  bit            m_sent [DEPTH];
  bit            m_wr   [DEPTH];
  logic [1:0]    m_lbl  [DEPTH];
  logic [AW-1:0] m_addr [DEPTH];
  bit            s_v;
  int            s_tag;
  logic [AW-1:0] s_addr;
  bit            s_wr;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_cnt();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) c += int'(m_busy[i]);
    return c;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < DEPTH; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic bit m_any(input bit acq_only);
    for (int i = 0; i < DEPTH; i++)
      if (m_busy[i] && (acq_only ? m_lbl[i][0] : (m_lbl[i] != 2'b00))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_any_rel();
    for (int i = 0; i < DEPTH; i++) if (m_busy[i] && m_lbl[i][1]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_haz(input logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++) if (m_busy[i] && m_wr[i] && m_addr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // ordering rules from R2..R5
  function automatic bit exp_order(input bit md, input logic [1:0] l);
    if (md == 1'b0) return !m_any(1'b0) && (l == 2'b00 || m_cnt() == 0);
    return !m_any(1'b1) && (!l[1] || m_cnt() == 0);
  endfunction

  function automatic string why(input bit md, input logic [1:0] l, input logic [AW-1:0] a,
                                input bit rdy);
    if (s_v && !rdy) return "R10";
    if (m_free() < 0) return "R9";
    if (md == 1'b0) begin
      if (m_any(1'b0)) return "R3";
      if (l != 2'b00 && m_cnt() > 0) return "R2";
    end else begin
      if (m_any(1'b1)) return "R4";
      if (l[1] && m_cnt() > 0) return "R5";
    end
    if (m_haz(a)) return "R8";
    if (md == 1'b1 && m_cnt() > 0 && (l != 2'b00 || m_any_rel())) return "R6";
    return "R7";
  endfunction

  // one cycle: drive at negedge, compare, update model at posedge
  task automatic step(input bit v, input logic [1:0] l, input logic [AW-1:0] a, input bit w,
                      input bit rdy, input bit ackv, input int ackt);
    bit    e_ready, e_stall, ord;
    int    fr;
    string rq;
    @(negedge clk);
    op_valid = v; op_label = l; op_addr = a; op_write = w;
    mem_req_ready = rdy; mem_ack_valid = ackv; mem_ack_tag = TW'(ackt);
    #1;
    fr      = m_free();
    ord     = exp_order(mode, l) && !m_haz(a);
    e_ready = (!s_v || rdy) && (fr >= 0) && ord;
    e_stall = v && !ord;
    rq      = why(mode, l, a, rdy);
    chk(op_ready == e_ready, rq, "op_ready", int'(op_ready), int'(e_ready));
    chk(stall == e_stall, "R11", "stall", int'(stall), int'(e_stall));
    chk(mem_req_valid == s_v, "R10", "mem_req_valid", int'(mem_req_valid), int'(s_v));
    if (s_v) begin
      chk(mem_req_tag == TW'(s_tag) && mem_req_addr == s_addr && mem_req_write == s_wr,
          "R10", "mem_req_tag", int'(mem_req_tag), s_tag);
    end
    @(posedge clk);
    if (ackv && m_busy[ackt]) begin
      m_busy[ackt] = 1'b0;
      m_sent[ackt] = 1'b0;
    end
    if (s_v && rdy) m_sent[s_tag] = 1'b1;
    if (v && e_ready) begin
      m_busy[fr] = 1'b1; m_sent[fr] = 1'b0;
      m_wr[fr] = w; m_lbl[fr] = l; m_addr[fr] = a;
      s_v = 1'b1; s_tag = fr; s_addr = a; s_wr = w;
    end else if (s_v && rdy) begin
      s_v = 1'b0;
    end
  endtask

  function automatic int pick_sent();
    int n = 0;
    int k;
    for (int i = 0; i < DEPTH; i++) n += int'(m_sent[i]);
    if (n == 0) return -1;
    k = $urandom_range(0, n - 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (m_sent[i]) begin
        if (k == 0) return i;
        k--;
      end
    end
    return -1;
  endfunction

  task automatic idle_ack();
    int t = pick_sent();
    step(1'b0, 2'b00, '0, 1'b0, 1'b1, t >= 0, (t >= 0) ? t : 0);
  endtask

  task automatic drain();
    for (int k = 0; k < 100 && (m_cnt() > 0 || s_v); k++) idle_ack();
  endtask

  task automatic rand_phase(input int n);
    for (int k = 0; k < n; k++) begin
      int r = $urandom_range(0, 99);
      logic [1:0] l = (r < 55) ? 2'b00 : (r < 70) ? 2'b01 : (r < 85) ? 2'b10 : 2'b11;
      int t = pick_sent();
      bit av = ($urandom_range(0, 99) < 45) && (t >= 0);
      int at = av ? t : int'($urandom_range(0, DEPTH - 1)); // stray tag when no real ack (R10)
      bit stray = !av && ($urandom_range(0, 99) < 5);
      step($urandom_range(0, 99) < 80, l, AW'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
           $urandom_range(0, 99) < 75, av || (stray && !m_busy[at]), at);
    end
  endtask

  initial begin
    #600000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h0bd3_71a5));
    for (int i = 0; i < DEPTH; i++) begin
      m_busy[i] = 0; m_sent[i] = 0; m_wr[i] = 0; m_lbl[i] = 0; m_addr[i] = 0;
    end
    s_v = 0; s_tag = 0; s_addr = 0; s_wr = 0;
    rst = 1; mode = 0; op_valid = 0; op_label = 0; op_write = 0; op_addr = 0;
    mem_req_ready = 0; mem_ack_valid = 0; mem_ack_tag = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", int'(mem_req_valid), 0);
    chk(op_ready == 1'b1, "R1", "op_ready after reset", int'(op_ready), 1);
    chk(stall == 1'b0, "R1", "stall after reset", int'(stall), 0);

    // weak ordering directed: R7 two data, R2 sync blocked, R3 fence
    mode = 1'b0;
    step(1, 2'b00, 16'h1, 1, 1, 0, 0);
    step(1, 2'b00, 16'h2, 0, 1, 0, 0);
    step(1, 2'b11, 16'h3, 1, 1, 0, 0);
    // stray ack of idle tag 5 must not free anything (R10)
    step(0, 2'b00, 16'h0, 0, 1, 1, 5);
    step(1, 2'b10, 16'h3, 1, 1, 0, 0);
    chk(op_ready == 1'b0, "R10", "sync after stray ack", int'(op_ready), 0);
    drain();
    step(1, 2'b01, 16'h3, 0, 1, 0, 0);
    step(1, 2'b00, 16'h2, 0, 1, 0, 0);
    drain();
    // R8: read after outstanding write, same address
    step(1, 2'b00, 16'h7, 1, 1, 0, 0);
    step(1, 2'b00, 16'h7, 0, 1, 0, 0);
    drain();
    // R9: fill all tags with reads
    for (int k = 0; k < DEPTH + 2; k++) step(1, 2'b00, AW'(k + 16), 0, 1, 0, 0);
    drain();
    rand_phase(2500);
    drain();

    // release consistency directed: R6 and R4, R5
    mode = 1'b1;
    step(1, 2'b10, 16'h2, 1, 1, 0, 0);
    step(1, 2'b00, 16'h3, 0, 1, 0, 0);
    step(1, 2'b01, 16'h3, 0, 1, 0, 0);
    step(1, 2'b00, 16'h4, 0, 1, 0, 0);
    step(1, 2'b10, 16'h5, 1, 1, 0, 0);
    drain();
    // R10: backpressure hold
    step(1, 2'b00, 16'h9, 1, 0, 0, 0);
    step(1, 2'b00, 16'ha, 1, 0, 0, 0);
    step(1, 2'b00, 16'ha, 1, 0, 0, 0);
    drain();
    rand_phase(2500);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule